// File: doc/BRIEF.md
# Eight-Bit Datapath ALU with Single-Bit Operations

This block is the purely combinational arithmetic unit of a small 8-bit controller core with 12-bit instructions. It takes two operands, a 4-bit operation code and a carry input, and returns a result, a carry-out and a zero indication. The surrounding core uses the carry-out and the zero indication to update its status flags. The core also reads the zero indication to decide whether the next instruction is skipped.

Several instruction-level idioms map onto these operations with no extra hardware. A register is cleared by XORing a value with itself. A value is moved by ORing it with zero. Increment and decrement are an add or subtract of the constant one on operand B. The single-bit operations take the bit number from the top three bits of operand B. The two bit tests leave operand A unchanged and report their outcome only on the zero output.

Top module: `mcu_alu`

## Requirements
- R1: Opcode 4'b0001 (add) gives result = (A + B) mod 256, and carry_o is bit 8 of the 9-bit sum.
- R2: Opcode 4'b0000 (subtract) gives result = (A - B) mod 256, and carry_o = 1 exactly when A >= B (carry is the inverse of borrow).
- R3: Opcode 4'b0010 gives A OR B, 4'b0011 gives A AND B and 4'b0100 gives A XOR B. A XOR of two equal operands yields 0 with zero_o = 1.
- R4: Opcode 4'b0101 gives the bitwise inverse of A. Opcode 4'b1100 exchanges the two nibbles of A.
- R5: Opcode 4'b0110 rotates A right through the carry: carry_i enters bit 7 and bit 0 leaves on carry_o. Opcode 4'b0111 rotates left: carry_i enters bit 0 and bit 7 leaves on carry_o.
- R6: The bit number is B[7:5]. Opcode 4'b1000 clears that bit of A and opcode 4'b1001 sets it; all other bits of A are kept.
- R7: Opcode 4'b1010 drives zero_o = 1 when the selected bit of A is 0. Opcode 4'b1011 drives zero_o = 1 when that bit is 1. Both tests output result = A.
- R8: For every opcode other than the two bit tests, zero_o = 1 exactly when the result is 0. Opcode 4'b1111 (no operation) and the unused codes 4'b1101 and 4'b1110 output result = A.
- R9: carry_o is 0 for every opcode other than add, subtract and the two rotates.
- R10: Adding B = 1 to 8'hFF gives 0 with carry_o = 1 and zero_o = 1. Subtracting B = 1 from 0 gives 8'hFF with carry_o = 0 and zero_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A (file value, W or literal, chosen by the core) |
| b_i | input | 8 | Operand B; bits 7:5 are the bit number for single-bit operations |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Carry input shifted in by the rotates |
| result_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry-out (inverse borrow for subtract) |
| zero_o | output | 1 | Zero indication; for bit tests, the skip request |

## Verification
Every output is combinational, so each result is due in the same cycle that the operands and opcode are applied, with no register on the path. The bench drives a new vector on each falling clock edge and samples all three outputs 2 ns later, which is well before the next rising edge. Each sample is compared with a reference computed in the bench using integer arithmetic rather than bit slicing.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

  typedef enum logic [3:0] {
    OP_SUB    = 4'b0000,
    OP_ADD    = 4'b0001,
    OP_OR     = 4'b0010,
    OP_AND    = 4'b0011,
    OP_XOR    = 4'b0100,
    OP_COM    = 4'b0101,
    OP_ROR    = 4'b0110,
    OP_ROL    = 4'b0111,
    OP_BCLR   = 4'b1000,
    OP_BSET   = 4'b1001,
    OP_TSTCLR = 4'b1010,
    OP_TSTSET = 4'b1011,
    OP_SWAP   = 4'b1100,
    OP_RSVD0  = 4'b1101,
    OP_RSVD1  = 4'b1110,
    OP_NOP    = 4'b1111
  } alu_op_e;

  localparam int OP_W = 4;

endpackage

// File: rtl/mcu_alu_bitsel.sv
// Decodes a bit number into a one-hot mask over the data word.
module mcu_alu_bitsel #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     mask_o
);

  for (genvar g = 0; g < W; g++) begin : g_dec
    assign mask_o[g] = (idx_i == IDX_W'(g));
  end

endmodule

// File: rtl/mcu_alu_arith.sv
// Shared adder: subtract is A + ~B + 1, so carry-out is the inverse borrow.
module mcu_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int EXT_W = W + 1;

  function automatic logic [EXT_W-1:0] add_ext(input logic [W-1:0] x,
                                               input logic [W-1:0] y,
                                               input logic         cin);
    return {1'b0, x} + {1'b0, y} + {{(EXT_W-1){1'b0}}, cin};
  endfunction

  logic [W-1:0]     b_eff;
  logic [EXT_W-1:0] ext;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign ext    = add_ext(a_i, b_eff, sub_i);
  assign sum_o  = ext[W-1:0];
  assign cout_o = ext[W];

endmodule

// File: rtl/mcu_alu_shift.sv
// Rotates through carry, complement and nibble exchange of operand A.
module mcu_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] ror_o,
  output logic         ror_c_o,
  output logic [W-1:0] rol_o,
  output logic         rol_c_o,
  output logic [W-1:0] com_o,
  output logic [W-1:0] swap_o
);

  localparam int HALF = W / 2;

  function automatic logic [W-1:0] rot_right(input logic [W-1:0] x, input logic c);
    return {c, x[W-1:1]};
  endfunction

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] x, input logic c);
    return {x[W-2:0], c};
  endfunction

  function automatic logic [W-1:0] half_swap(input logic [W-1:0] x);
    return {x[HALF-1:0], x[W-1:HALF]};
  endfunction

  assign ror_o   = rot_right(a_i, cin_i);
  assign ror_c_o = a_i[0];
  assign rol_o   = rot_left(a_i, cin_i);
  assign rol_c_o = a_i[W-1];
  assign com_o   = ~a_i;
  assign swap_o  = half_swap(a_i);

endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_i,
  output logic [W-1:0]    result_o,
  output logic            carry_o,
  output logic            zero_o
);

  localparam int IDX_W = $clog2(W);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Named internal events used by the bound checker.
  logic [IDX_W-1:0] bit_idx;
  logic [W-1:0]     bit_mask;
  logic             bit_hit;
  logic             is_test;
  logic [W-1:0]     arith_sum;
  logic             arith_cout;
  logic [W-1:0]     ror_v, rol_v, com_v, swap_v;
  logic             ror_c, rol_c;
  logic [W-1:0]     res_mux;

  assign bit_idx = b_i[W-1 -: IDX_W];

  mcu_alu_bitsel #(.W(W), .IDX_W(IDX_W)) u_bitsel (
    .idx_i  (bit_idx),
    .mask_o (bit_mask)
  );

  mcu_alu_arith #(.W(W)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (op == OP_SUB),
    .sum_o  (arith_sum),
    .cout_o (arith_cout)
  );

  mcu_alu_shift #(.W(W)) u_shift (
    .a_i     (a_i),
    .cin_i   (carry_i),
    .ror_o   (ror_v),
    .ror_c_o (ror_c),
    .rol_o   (rol_v),
    .rol_c_o (rol_c),
    .com_o   (com_v),
    .swap_o  (swap_v)
  );

  assign bit_hit = |(a_i & bit_mask);
  assign is_test = (op == OP_TSTCLR) || (op == OP_TSTSET);

  always_comb begin
    res_mux = a_i;
    carry_o = 1'b0;
    unique case (op)
      OP_SUB, OP_ADD: begin
        res_mux = arith_sum;
        carry_o = arith_cout;
      end
      OP_OR:   res_mux = a_i | b_i;
      OP_AND:  res_mux = a_i & b_i;
      OP_XOR:  res_mux = a_i ^ b_i;
      OP_COM:  res_mux = com_v;
      OP_ROR: begin
        res_mux = ror_v;
        carry_o = ror_c;
      end
      OP_ROL: begin
        res_mux = rol_v;
        carry_o = rol_c;
      end
      OP_BCLR: res_mux = a_i & ~bit_mask;
      OP_BSET: res_mux = a_i | bit_mask;
      OP_SWAP: res_mux = swap_v;
      default: res_mux = a_i;
    endcase
  end

  always_comb begin
    if (op == OP_TSTCLR)      zero_o = ~bit_hit;
    else if (op == OP_TSTSET) zero_o = bit_hit;
    else                      zero_o = (res_mux == '0);
  end

  assign result_o = res_mux;

endmodule

// File: rtl/mcu_alu_chk.sv
module mcu_alu_chk
  import mcu_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [OP_W-1:0] op_i,
  input logic            carry_i,
  input logic [W-1:0]    result_o,
  input logic            carry_o,
  input logic            zero_o,
  input logic [W-1:0]    bit_mask,
  input logic            is_test
);

  always_comb begin
    // R6
    mask_onehot_chk: assert ($onehot(bit_mask));
    // R7
    if (is_test) begin
      test_passthru_chk: assert (result_o == a_i);
    end
    // R8
    if (!is_test) begin
      zero_match_chk: assert (zero_o == (result_o == '0));
    end
    // R9
    if (op_i != OP_ADD && op_i != OP_SUB && op_i != OP_ROR && op_i != OP_ROL) begin
      carry_quiet_chk: assert (!carry_o);
    end
    // R2
    if (op_i == OP_SUB) begin
      sub_borrow_chk: assert (carry_o == (a_i >= b_i));
    end
    // R5
    if (op_i == OP_ROR) begin
      ror_out_chk: assert (carry_o == a_i[0] && result_o[W-1] == carry_i);
    end
  end

endmodule

bind mcu_alu mcu_alu_chk #(.W(W)) u_alu_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .carry_i  (carry_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .zero_o   (zero_o),
  .bit_mask (bit_mask),
  .is_test  (is_test)
);

// File: tb/mcu_alu_bench.sv
`timescale 1ns/1ps
module mcu_alu_bench;

  localparam logic [3:0] C_SUB = 4'b0000, C_ADD = 4'b0001, C_OR = 4'b0010,
                         C_AND = 4'b0011, C_XOR = 4'b0100, C_COM = 4'b0101,
                         C_ROR = 4'b0110, C_ROL = 4'b0111, C_BCLR = 4'b1000,
                         C_BSET = 4'b1001, C_TCLR = 4'b1010, C_TSET = 4'b1011,
                         C_SWAP = 4'b1100, C_NOP = 4'b1111;

  logic       clk = 1'b0;
  logic [7:0] a = 8'h00, b = 8'h00;
  logic [3:0] op = 4'b0000;
  logic       cin = 1'b0;
  logic [7:0] res;
  logic       cout, zero;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  mcu_alu u_mcu_alu (
    .a_i(a), .b_i(b), .op_i(op), .carry_i(cin),
    .result_o(res), .carry_o(cout), .zero_o(zero)
  );

  // Reference written with integer arithmetic.
  task automatic model(input logic [3:0] o, input int x, input int y, input int c,
                       output int r, output int co, output int z);
    int n;
    n  = y / 32;
    co = 0;
    r  = x;
    case (o)
      C_ADD:  begin r = (x + y) % 256; co = (x + y >= 256) ? 1 : 0; end
      C_SUB:  begin r = (x - y + 256) % 256; co = (x >= y) ? 1 : 0; end
      C_OR:   r = x | y;
      C_AND:  r = x & y;
      C_XOR:  r = x ^ y;
      C_COM:  r = 255 - x;
      C_ROR:  begin r = x / 2 + c * 128; co = x % 2; end
      C_ROL:  begin r = (x * 2) % 256 + c; co = x / 128; end
      C_SWAP: r = (x % 16) * 16 + x / 16;
      C_BCLR: r = x & (255 - (1 << n));
      C_BSET: r = x | (1 << n);
      default: r = x;
    endcase
    if (o == C_TCLR)      z = (((x >> n) & 1) == 0) ? 1 : 0;
    else if (o == C_TSET) z = (((x >> n) & 1) == 1) ? 1 : 0;
    else                  z = (r == 0) ? 1 : 0;
  endtask

  task automatic apply(input string tag, input logic [3:0] o, input int x,
                       input int y, input int c);
    int er, ec, ez;
    @(negedge clk);
    op = o; a = 8'(x); b = 8'(y); cin = c[0];
    #2;
    model(o, x, y, c, er, ec, ez);
    checks++;
    if (int'(res) != er || int'(cout) != ec || int'(zero) != ez) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h c=%0d : got r=%h c=%0d z=%0d exp r=%h c=%0d z=%0d",
               tag, o, x[7:0], y[7:0], c, res, cout, zero, er[7:0], ec, ez);
    end
  endtask

  task automatic sweep(input string tag, input logic [3:0] o);
    for (int i = 0; i < 48; i++) begin
      apply(tag, o, (i * 37 + 5) % 256, (i * 91 + 3) % 256, i % 2);
    end
  endtask

  task automatic t_idle;
    // all-zero inputs: subtract 0-0 -> 0, carry 1, zero 1 (R2)
    #3;
    checks++;
    if (res !== 8'h00 || cout !== 1'b1 || zero !== 1'b1) begin
      bad++;
      $display("FAIL R2 idle: got r=%h c=%b z=%b exp r=00 c=1 z=1", res, cout, zero);
    end
  endtask

  task automatic t_add;
    sweep("R1", C_ADD);
    apply("R1", C_ADD, 128, 128, 0);
    apply("R1", C_ADD, 255, 254, 1);
    apply("R1", C_ADD, 0, 0, 1);
  endtask

  task automatic t_sub;
    sweep("R2", C_SUB);
    apply("R2", C_SUB, 77, 77, 0);
    apply("R2", C_SUB, 0, 255, 0);
    apply("R2", C_SUB, 255, 0, 1);
  endtask

  task automatic t_logic;
    sweep("R3", C_OR);
    sweep("R3", C_AND);
    sweep("R3", C_XOR);
    apply("R3", C_XOR, 8'hA5, 8'hA5, 0);
    apply("R3", C_OR, 0, 0, 1);
    apply("R3", C_OR, 8'h3C, 0, 0);
  endtask

  task automatic t_com_swap;
    sweep("R4", C_COM);
    sweep("R4", C_SWAP);
    apply("R4", C_COM, 255, 0, 0);
    apply("R4", C_SWAP, 8'hF0, 0, 0);
  endtask

  task automatic t_rotate;
    sweep("R5", C_ROR);
    sweep("R5", C_ROL);
    apply("R5", C_ROR, 1, 0, 0);
    apply("R5", C_ROL, 128, 0, 0);
    apply("R5", C_ROL, 0, 0, 1);
  endtask

  task automatic t_bits;
    for (int n = 0; n < 8; n++) begin
      apply("R6", C_BCLR, 255, n * 32 + 7, 0);
      apply("R6", C_BSET, 0, n * 32 + 19, 1);
      apply("R7", C_TCLR, 255 - (1 << n), n * 32, 0);
      apply("R7", C_TCLR, 1 << n, n * 32, 0);
      apply("R7", C_TSET, 1 << n, n * 32, 1);
      apply("R7", C_TSET, 0, n * 32, 0);
    end
    sweep("R6", C_BCLR);
    sweep("R6", C_BSET);
    sweep("R7", C_TCLR);
    sweep("R7", C_TSET);
  endtask

  task automatic t_misc;
    sweep("R8", C_NOP);
    sweep("R8", 4'b1101);
    sweep("R8", 4'b1110);
    apply("R8", C_NOP, 0, 255, 1);
    apply("R9", C_AND, 255, 255, 1);
    apply("R9", C_BSET, 255, 0, 1);
  endtask

  task automatic t_incdec;
    apply("R10", C_ADD, 255, 1, 0);
    apply("R10", C_SUB, 0, 1, 0);
    apply("R10", C_ADD, 41, 1, 1);
    apply("R10", C_SUB, 1, 1, 0);
  endtask

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_com_swap();
    t_rotate();
    t_bits();
    t_misc();
    t_incdec();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule